// File: doc/BRIEF.md
# ATA Task-File Register Block with Command Sequencer

This block is the device side of a parallel ATA disk's register window. It has eight byte offsets. The host uses them to load a sector count, a 24-bit LBA and a device-select byte, to write a command and to poll status. A 16-bit data port returns the 256-word identification block by programmed I/O. The block decodes four commands: identify, cache flush, DMA read and DMA write.

The sequencer drives the busy, ready, data-request and error status bits, and it drives a level interrupt. Cache flushes and DMA transfers are passed on to a backend through request levels. Each request stays high until the backend returns a one-cycle done pulse. The media and the DMA engine sit outside this block.

Register reads take effect on the clock edge where `io_rd_i` is high. The read data is combinational from `io_addr_i`, so the host samples `io_rdata_o` before that edge.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, status (offset 7) reads 0x40, meaning ready with busy (0x80), data request (0x08) and error (0x01) clear. Offsets 2 to 6 read 0 and `irq_o` is low.
- R2: Byte writes read back at these offsets: 2 is the sector count, 3, 4 and 5 are the LBA low, mid and high bytes, and 6 is the device byte. Offset 1 reads 0.
- R3: Command 0xEC (identify) raises `irq_o` and sets status to 0x48. Each of the 256 reads of offset 0 finds status 0x48. After the 256th read, status returns to 0x40.
- R4: The identify words are as follows. Words 10 to 19 carry the 20-character serial string and words 23 to 26 carry the 8-character firmware string, with the earlier character of each pair in bits 15:8. Word 85 is 0x0020, which reports the write cache as enabled. Every other word is 0.
- R5: Command 0xE7 (flush) raises `flush_req_o` and status reads 0xC0. A `flush_done_i` pulse drops the request, returns status to 0x40 and raises `irq_o`.
- R6: Commands 0xC8 (DMA read) and 0xCA (DMA write) raise `dma_req_o` with status 0xC0. While the request is high, `dma_lba_o` is {high, mid, low} and `dma_sectors_o` is the count, where a count of 0 means 256. `dma_to_media_o` is 1 only for 0xCA. A `dma_done_i` pulse returns status to 0x40 and raises `irq_o`.
- R7: A read of offset 7 clears `irq_o` on that edge.
- R8: Any other command code sets status 0x41 and raises `irq_o`. The next accepted valid command clears the error bit.
- R9: While busy is set, writes to offsets 2 to 7 are ignored.
- R10: With device byte bit 4 set (device 1, absent), a command write is ignored: status and `irq_o` are unchanged.
- R11: A read of offset 0 while data request is clear returns 0 and leaves status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_addr_i | input | 3 | Register offset |
| io_wr_i | input | 1 | Register write strobe |
| io_rd_i | input | 1 | Register read strobe (side effects on this edge) |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 16 | Read data for the addressed offset |
| irq_o | output | 1 | Interrupt request level |
| flush_req_o | output | 1 | Cache flush outstanding |
| flush_done_i | input | 1 | Flush completion pulse |
| dma_req_o | output | 1 | DMA transfer outstanding |
| dma_to_media_o | output | 1 | 1 = host-to-media transfer |
| dma_lba_o | output | 24 | Start LBA |
| dma_sectors_o | output | 9 | Sector count, 1 to 256 |
| dma_done_i | input | 1 | DMA completion pulse |

## Verification
The identify test walks all 256 words. A counter that stops one short or one late leaves data request set or clears it early, and a swapped byte order garbles the serial and firmware strings. A sector count of 0 must come out as 256; a plain zero-extension would hand the DMA engine an empty transfer. Register and command writes made during a flush must leave the LBA and status untouched; a design that accepts them corrupts an in-flight request. A command aimed at the absent device, an illegal opcode and a data read with no transfer pending each have a fixed status outcome; any stray interrupt or index advance shows up in the next status read.

// File: rtl/ata_pkg.sv
package ata_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_CNT  = 3'd2;
  localparam logic [2:0] OFS_LBA0 = 3'd3;
  localparam logic [2:0] OFS_LBA1 = 3'd4;
  localparam logic [2:0] OFS_LBA2 = 3'd5;
  localparam logic [2:0] OFS_DEV  = 3'd6;
  localparam logic [2:0] OFS_STCMD = 3'd7;

  localparam int DEV1_BIT = 4;

  localparam logic [7:0] OP_DMA_IN  = 8'hC8;
  localparam logic [7:0] OP_DMA_OUT = 8'hCA;
  localparam logic [7:0] OP_FLUSH   = 8'hE7;
  localparam logic [7:0] OP_IDENT   = 8'hEC;

  typedef enum logic [1:0] {
    ST_IDLE, ST_PIO, ST_FLUSH, ST_DMA
  } seq_st_e;

  function automatic logic [7:0] pack_status(logic bsy, logic drq, logic err);
    return {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err};
  endfunction
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        lock_i,
  output logic [7:0]  cnt_o,
  output logic [23:0] lba_o,
  output logic [7:0]  dev_o
);
  logic [7:0] lba0_q, lba1_q, lba2_q;
  logic       wr_ok;

  assign wr_ok = wr_i && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      lba0_q <= '0;
      lba1_q <= '0;
      lba2_q <= '0;
      dev_o  <= '0;
    end else if (wr_ok) begin
      unique case (addr_i)
        OFS_CNT:  cnt_o  <= wdata_i;
        OFS_LBA0: lba0_q <= wdata_i;
        OFS_LBA1: lba1_q <= wdata_i;
        OFS_LBA2: lba2_q <= wdata_i;
        OFS_DEV:  dev_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign lba_o = {lba2_q, lba1_q, lba0_q};

  // R9: registers hold while locked
  assert_lock_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(lba_o) && $stable(cnt_o) && $stable(dev_o));
endmodule

// File: rtl/ata_id_gen.sv
module ata_id_gen #(
  parameter int          ID_WORDS   = 256,
  parameter int          SER_CHARS  = 20,
  parameter int          FW_CHARS   = 8,
  parameter logic [8*SER_CHARS-1:0] SERIAL_STR = "DEFAULTSN0001       ",
  parameter logic [8*FW_CHARS-1:0]  FW_STR     = "fw1.0   ",
  localparam int         IDX_W = $clog2(ID_WORDS)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [15:0]      word_o
);
  localparam int SER_BASE  = 10;
  localparam int SER_WORDS = SER_CHARS / 2;
  localparam int FW_BASE   = 23;
  localparam int FW_WORDS  = FW_CHARS / 2;
  localparam int CAP_WORD  = 85;
  localparam int SER_BITS  = 8 * SER_CHARS;
  localparam int FW_BITS   = 8 * FW_CHARS;

  logic [15:0] rom [ID_WORDS];

  // Packed strings hold the first character in the top byte, so each
  // 16-bit slice already has the earlier character high.
  for (genvar g = 0; g < ID_WORDS; g++) begin : g_word
    if (g >= SER_BASE && g < SER_BASE + SER_WORDS) begin : g_ser
      assign rom[g] = SERIAL_STR[SER_BITS-1-16*(g-SER_BASE) -: 16];
    end else if (g >= FW_BASE && g < FW_BASE + FW_WORDS) begin : g_fw
      assign rom[g] = FW_STR[FW_BITS-1-16*(g-FW_BASE) -: 16];
    end else if (g == CAP_WORD) begin : g_cap
      assign rom[g] = 16'h0020;
    end else begin : g_zero
      assign rom[g] = '0;
    end
  end

  assign word_o = rom[idx_i];
endmodule

// File: rtl/ata_cmd_seq.sv
module ata_cmd_seq
  import ata_pkg::*;
#(
  parameter int ID_WORDS = 256,
  localparam int IDX_W = $clog2(ID_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [7:0]       cmd_i,
  input  logic             dev1_i,
  input  logic             status_rd_i,
  input  logic             data_rd_i,
  input  logic             flush_done_i,
  input  logic             dma_done_i,
  output logic             bsy_o,
  output logic             drq_o,
  output logic             err_o,
  output logic             irq_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             flush_req_o,
  output logic             dma_req_o,
  output logic             dma_to_media_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_WORDS - 1);

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             err_q, err_d, irq_q, irq_d, dir_q, dir_d;
  logic             set_irq, cmd_go;

  assign bsy_o = (st_q == ST_FLUSH) || (st_q == ST_DMA);
  assign drq_o = (st_q == ST_PIO);
  assign cmd_go = cmd_wr_i && !bsy_o && !dev1_i;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    err_d   = err_q;
    dir_d   = dir_q;
    set_irq = 1'b0;
    unique case (st_q)
      ST_PIO: if (data_rd_i) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) st_d = ST_IDLE;
      end
      ST_FLUSH: if (flush_done_i) begin
        st_d    = ST_IDLE;
        set_irq = 1'b1;
      end
      ST_DMA: if (dma_done_i) begin
        st_d    = ST_IDLE;
        set_irq = 1'b1;
      end
      default: ;
    endcase
    if (cmd_go) begin
      err_d = 1'b0;
      unique case (cmd_i)
        OP_IDENT: begin
          st_d    = ST_PIO;
          idx_d   = '0;
          set_irq = 1'b1;
        end
        OP_FLUSH:  st_d = ST_FLUSH;
        OP_DMA_IN, OP_DMA_OUT: begin
          st_d  = ST_DMA;
          dir_d = (cmd_i == OP_DMA_OUT);
        end
        default: begin
          st_d    = ST_IDLE;
          err_d   = 1'b1;
          set_irq = 1'b1;
        end
      endcase
    end
    irq_d = set_irq ? 1'b1 : (status_rd_i ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      err_q <= err_d;
      irq_q <= irq_d;
      dir_q <= dir_d;
    end
  end

  assign err_o          = err_q;
  assign irq_o          = irq_q;
  assign idx_o          = idx_q;
  assign flush_req_o    = (st_q == ST_FLUSH);
  assign dma_req_o      = (st_q == ST_DMA);
  assign dma_to_media_o = dir_q;

  assert_irq_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !cmd_wr_i && !flush_done_i && !dma_done_i) |=> !irq_o);
  assert_flush_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_req_o && flush_done_i) |=> (!bsy_o && irq_o && !err_o));
  assert_pio_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drq_o && data_rd_i && idx_o == LAST_IDX && !cmd_wr_i) |=> (!drq_o && !bsy_o));
  assert_pio_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drq_o && data_rd_i && idx_o != LAST_IDX && !cmd_wr_i) |=> (drq_o && idx_o == $past(idx_o) + 1'b1));
  assert_dev1_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && dev1_i && !bsy_o && !drq_o) |=> ($stable(bsy_o) && $stable(drq_o) && $stable(err_o)));
  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsy_o && cmd_wr_i && !flush_done_i && !dma_done_i) |=> (bsy_o && $stable(err_o)));
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_pkg::*;
#(
  parameter int ID_WORDS  = 256,
  parameter int SER_CHARS = 20,
  parameter int FW_CHARS  = 8,
  parameter logic [8*SER_CHARS-1:0] SERIAL_STR = "DEFAULTSN0001       ",
  parameter logic [8*FW_CHARS-1:0]  FW_STR     = "fw1.0   ",
  localparam int IDX_W = $clog2(ID_WORDS)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  io_addr_i,
  input  logic        io_wr_i,
  input  logic        io_rd_i,
  input  logic [7:0]  io_wdata_i,
  output logic [15:0] io_rdata_o,
  output logic        irq_o,
  output logic        flush_req_o,
  input  logic        flush_done_i,
  output logic        dma_req_o,
  output logic        dma_to_media_o,
  output logic [23:0] dma_lba_o,
  output logic [8:0]  dma_sectors_o,
  input  logic        dma_done_i
);
  logic [7:0]       cnt, dev;
  logic [23:0]      lba;
  logic             bsy, drq, err;
  logic [IDX_W-1:0] idx;
  logic [15:0]      id_word;
  logic             cmd_wr, status_rd, data_rd;

  assign cmd_wr    = io_wr_i && (io_addr_i == OFS_STCMD);
  assign status_rd = io_rd_i && (io_addr_i == OFS_STCMD);
  assign data_rd   = io_rd_i && (io_addr_i == OFS_DATA);

  ata_tf_regs i_regs (
    .clk_i, .rst_ni,
    .wr_i(io_wr_i), .addr_i(io_addr_i), .wdata_i(io_wdata_i),
    .lock_i(bsy),
    .cnt_o(cnt), .lba_o(lba), .dev_o(dev)
  );

  ata_id_gen #(
    .ID_WORDS(ID_WORDS), .SER_CHARS(SER_CHARS), .FW_CHARS(FW_CHARS),
    .SERIAL_STR(SERIAL_STR), .FW_STR(FW_STR)
  ) i_id (
    .idx_i(idx), .word_o(id_word)
  );

  ata_cmd_seq #(.ID_WORDS(ID_WORDS)) i_seq (
    .clk_i, .rst_ni,
    .cmd_wr_i(cmd_wr), .cmd_i(io_wdata_i), .dev1_i(dev[DEV1_BIT]),
    .status_rd_i(status_rd), .data_rd_i(data_rd),
    .flush_done_i, .dma_done_i,
    .bsy_o(bsy), .drq_o(drq), .err_o(err), .irq_o,
    .idx_o(idx), .flush_req_o, .dma_req_o, .dma_to_media_o
  );

  always_comb begin
    unique case (io_addr_i)
      OFS_DATA:  io_rdata_o = drq ? id_word : 16'h0000;
      OFS_CNT:   io_rdata_o = {8'h00, cnt};
      OFS_LBA0:  io_rdata_o = {8'h00, lba[7:0]};
      OFS_LBA1:  io_rdata_o = {8'h00, lba[15:8]};
      OFS_LBA2:  io_rdata_o = {8'h00, lba[23:16]};
      OFS_DEV:   io_rdata_o = {8'h00, dev};
      OFS_STCMD: io_rdata_o = {8'h00, pack_status(bsy, drq, err)};
      default:   io_rdata_o = 16'h0000;
    endcase
  end

  assign dma_lba_o     = lba;
  assign dma_sectors_o = (cnt == 8'd0) ? 9'd256 : {1'b0, cnt};

  assert_dma_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && !dma_done_i) |=> (dma_req_o && $stable(dma_lba_o) &&
                                    $stable(dma_sectors_o) && $stable(dma_to_media_o)));
  assert_req_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dma_req_o && flush_req_o));
endmodule

// File: tb/test_ata_taskfile.sv
`timescale 1ns/1ps
module test_ata_taskfile;
  localparam logic [159:0] SER_V = "BENCHSN-0077        ";
  localparam logic [63:0]  FW_V  = "v2.1    ";
  string ser_s = "BENCHSN-0077        ";
  string fw_s  = "v2.1    ";

  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = 0;
  logic [15:0] rdata;
  logic irq, freq, fdone = 0, dreq, dto, ddone = 0;
  logic [23:0] dlba;
  logic [8:0] dsec;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  ata_taskfile #(.SERIAL_STR(SER_V), .FW_STR(FW_V)) i_ata_taskfile (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .irq_o(irq),
    .flush_req_o(freq), .flush_done_i(fdone), .dma_req_o(dreq),
    .dma_to_media_o(dto), .dma_lba_o(dlba), .dma_sectors_o(dsec), .dma_done_i(ddone)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic pulse(input bit is_dma);
    @(negedge clk); if (is_dma) ddone = 1; else fdone = 1;
    @(posedge clk); #1 ddone = 0; fdone = 0;
  endtask

  function automatic logic [15:0] exp_word(int i);
    if (i >= 10 && i < 20) return {ser_s[2*(i-10)], ser_s[2*(i-10)+1]};
    if (i >= 23 && i < 27) return {fw_s[2*(i-23)], fw_s[2*(i-23)+1]};
    if (i == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    rd_reg(7, d); check("R1 status", d, 16'h40);
    check("R1 irq", irq, 0);
    for (int a = 2; a <= 6; a++) begin rd_reg(a[2:0], d); check("R1 reg", d, 0); end
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr_reg(2, 8'h11); wr_reg(3, 8'h22); wr_reg(4, 8'h33); wr_reg(5, 8'h44); wr_reg(6, 8'h40);
    rd_reg(2, d); check("R2 count", d, 16'h11);
    rd_reg(3, d); check("R2 lba lo", d, 16'h22);
    rd_reg(4, d); check("R2 lba mid", d, 16'h33);
    rd_reg(5, d); check("R2 lba hi", d, 16'h44);
    rd_reg(6, d); check("R2 dev", d, 16'h40);
    rd_reg(1, d); check("R2 ofs1", d, 16'h0);
  endtask

  task automatic t_identify();
    logic [15:0] s, d;
    int bad_st = 0, bad_w = 0;
    wr_reg(7, 8'hEC);
    check("R3 irq on ready", irq, 1);
    rd_reg(7, s); check("R7 irq cleared", irq, 0);
    for (int i = 0; i < 256; i++) begin
      rd_reg(7, s);
      if (s !== 16'h48) bad_st++;
      rd_reg(0, d);
      if (d !== exp_word(i)) begin
        bad_w++;
        $display("FAIL R4 word %0d: got 0x%0h expected 0x%0h", i, d, exp_word(i));
      end
    end
    check("R3 status during words", bad_st, 0);
    checks++; if (bad_w != 0) fails++;
    rd_reg(7, s); check("R3 status after last", s, 16'h40);
    rd_reg(0, d); check("R11 idle data", d, 16'h0);
    rd_reg(7, s); check("R11 status unchanged", s, 16'h40);
    rd_reg(6, d); check("R2 dev bit4 clear", d[4], 0);
  endtask

  task automatic t_flush_busy();
    logic [15:0] s, d;
    wr_reg(3, 8'h5A);
    wr_reg(7, 8'hE7);
    check("R5 flush req", freq, 1);
    rd_reg(7, s); check("R5 busy status", s, 16'hC0);
    wr_reg(3, 8'h99);
    wr_reg(7, 8'hEC);
    rd_reg(7, s); check("R9 cmd ignored busy", s, 16'hC0);
    check("R9 no irq busy", irq, 0);
    pulse(0);
    check("R5 req dropped", freq, 0);
    check("R5 irq", irq, 1);
    rd_reg(7, s); check("R5 done status", s, 16'h40);
    check("R7 irq clear", irq, 0);
    rd_reg(3, d); check("R9 lba write ignored", d, 16'h5A);
  endtask

  task automatic t_dma();
    logic [15:0] s;
    wr_reg(2, 8'h00); wr_reg(3, 8'h56); wr_reg(4, 8'h34); wr_reg(5, 8'h12);
    wr_reg(7, 8'hC8);
    check("R6 dma req", dreq, 1);
    check("R6 lba", dlba, 24'h123456);
    check("R6 count0=256", dsec, 256);
    check("R6 dir read", dto, 0);
    rd_reg(7, s); check("R6 busy", s, 16'hC0);
    pulse(1);
    check("R6 irq", irq, 1);
    rd_reg(7, s); check("R6 done", s, 16'h40);
    wr_reg(2, 8'h03);
    wr_reg(7, 8'hCA);
    check("R6 dir write", dto, 1);
    check("R6 count3", dsec, 3);
    pulse(1);
    check("R6 req dropped", dreq, 0);
    rd_reg(7, s);
  endtask

  task automatic t_badcmd();
    logic [15:0] s;
    wr_reg(7, 8'h42);
    check("R8 irq", irq, 1);
    rd_reg(7, s); check("R8 err status", s, 16'h41);
    wr_reg(7, 8'hE7); pulse(0);
    rd_reg(7, s); check("R8 err cleared", s, 16'h40);
  endtask

  task automatic t_dev1();
    logic [15:0] s;
    wr_reg(6, 8'h50);
    wr_reg(7, 8'hEC);
    check("R10 no irq", irq, 0);
    rd_reg(7, s); check("R10 status", s, 16'h40);
    wr_reg(7, 8'hE7);
    check("R10 no flush", freq, 0);
    wr_reg(6, 8'h40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_regs();
    t_identify();
    t_flush_busy();
    t_dma();
    t_badcmd();
    t_dev1();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule